// File: doc/BRIEF.md
# Pipeline RAW Stall Detector

This block watches the instruction in decode and the three older instructions held in the execute, memory and write-back pipeline registers. It reports when a source register of the decode instruction is still to be written by one of the older ones. When it finds such a read-after-write dependence it produces three stall controls: the program counter is held, the fetch/decode register is held, and a no-op is sent into the execute register. That no-op is the bubble. WAR and WAW ordering cannot be broken in a five-stage in-order pipe, so only RAW dependences are checked. The block is purely combinational, and its outputs are meant to gate the same cycle's register enables.

A comparison is made only when it matters. The source must be one the decode instruction really reads, the older instruction must really write a register, and register 0 is never a dependence. A mode parameter chooses how the unit pairs with the datapath. In stall-only mode, for pipes without bypass paths, every older stage is compared. In load-use mode, for pipes with full forwarding, only a load in execute can stall. A second parameter drops the write-back comparison when the register file writes in the first half of the cycle and reads in the second half.

Top module: `hazard_unit`

## Requirements
- R1: In stall-only mode, a stall is raised when the execute-stage instruction has its write flag set and its destination equals a source that decode reads.
- R2: In stall-only mode, a stall is raised when the memory-stage instruction writes a destination equal to a read source of decode.
- R3: In stall-only mode with WRITE_FIRST=0, a match against the write-back stage stalls. With WRITE_FIRST=1, a write-back match has no effect on the outputs.
- R4: An older instruction whose write flag is clear (for example a store) never causes a stall, whatever its destination field holds.
- R5: A source whose used flag is 0 (for example the second source of an immediate add or a jump) never causes a stall.
- R6: A source register number of 0 never causes a stall, even when an older stage writes register 0.
- R7: Outputs are coded as {pc_we_o, ifid_we_o, bubble_o}. They are 3'b110 with no stall and 3'b001 on a stall.
- R8: In load-use mode (MODE=MODE_LOAD_USE), a stall is raised only when the execute stage has both its write flag and its memory-read flag set and its destination matches a read source. A match with the memory or write-back stage has no effect.
- R9: Register numbers are compared on all REG_W bits, so numbers that differ only in the top bit do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src1_i | input | REG_W | First source register number of the decode instruction |
| src1_used_i | input | 1 | Decode instruction reads its first source |
| src2_i | input | REG_W | Second source register number of the decode instruction |
| src2_used_i | input | 1 | Decode instruction reads its second source |
| ex_dst_i | input | REG_W | Destination register number in the execute-stage register |
| ex_wr_i | input | 1 | Execute-stage instruction writes a register |
| ex_rd_i | input | 1 | Execute-stage instruction is a memory load |
| mem_dst_i | input | REG_W | Destination register number in the memory-stage register |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| wb_dst_i | input | REG_W | Destination register number in the write-back register |
| wb_wr_i | input | 1 | Write-back instruction writes a register |
| pc_we_o | output | 1 | Program counter update enable, 0 while stalling |
| ifid_we_o | output | 1 | Fetch/decode register update enable, 0 while stalling |
| bubble_o | output | 1 | Select the no-op into the execute register |

## Verification
Three copies run side by side on the same stimulus: stall-only with the write-back compare, load-use, and stall-only with a write-first register file. A match placed in each stage in turn therefore shows which stages each configuration looks at. A plain ALU writer in execute is set against a load writer in execute to separate the two modes. Matches masked by a clear write flag, a clear used flag, register 0 or a top-bit-only difference check that each qualifier works on its own, because each of those cases would stall if that one qualifier were missing.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned NUM_STG = 3;

  localparam int unsigned STG_EX  = 0;
  localparam int unsigned STG_MEM = 1;
  localparam int unsigned STG_WB  = 2;

  typedef enum logic {
    MODE_STALL_ONLY = 1'b0,
    MODE_LOAD_USE   = 1'b1
  } hz_mode_e;

  localparam logic [2:0] CTRL_RUN   = 3'b110;
  localparam logic [2:0] CTRL_STALL = 3'b001;
endpackage

// File: rtl/hz_src_qual.sv
module hz_src_qual #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] reg_i,
  input  logic             used_i,
  output logic             live_o
);
  // register 0 is hardwired, never a producer dependence
  assign live_o = used_i & (|reg_i);
endmodule

// File: rtl/hz_stage_cmp.sv
module hz_stage_cmp #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] src_i,
  input  logic [NUM_SRC-1:0]            live_i,
  input  logic [REG_W-1:0]              dst_i,
  input  logic                          wr_i,
  output logic                          hit_o
);
  logic [NUM_SRC-1:0] match;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign match[s] = live_i[s] & (src_i[s] == dst_i);
  end

  assign hit_o = wr_i & (|match);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
  import hz_pkg::*;
#(
  parameter hz_mode_e MODE        = MODE_STALL_ONLY,
  parameter bit       WRITE_FIRST = 1'b0
) (
  input  logic [NUM_STG-1:0] hit_i,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               bubble_o
);
  localparam logic USE_MEM = (MODE == MODE_STALL_ONLY);
  localparam logic USE_WB  = (MODE == MODE_STALL_ONLY) && !WRITE_FIRST;
  localparam logic [NUM_STG-1:0] STG_MASK = {USE_WB, USE_MEM, 1'b1};

  logic stall;

  assign stall = |(hit_i & STG_MASK);

  always_comb begin
    {pc_we_o, ifid_we_o, bubble_o} = stall ? CTRL_STALL : CTRL_RUN;
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_W       = 5,
  parameter hz_mode_e    MODE        = MODE_STALL_ONLY,
  parameter bit          WRITE_FIRST = 1'b0
) (
  input  logic [REG_W-1:0] src1_i,
  input  logic             src1_used_i,
  input  logic [REG_W-1:0] src2_i,
  input  logic             src2_used_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             ex_wr_i,
  input  logic             ex_rd_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_wr_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_wr_i,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o
);
  localparam logic LOAD_ONLY = (MODE == MODE_LOAD_USE);

  logic [NUM_SRC-1:0][REG_W-1:0] src;
  logic [NUM_SRC-1:0]            used;
  logic [NUM_SRC-1:0]            live;
  logic [NUM_STG-1:0][REG_W-1:0] stg_dst;
  logic [NUM_STG-1:0]            stg_wr;
  logic [NUM_STG-1:0]            hit;

  assign src  = {src2_i, src1_i};
  assign used = {src2_used_i, src1_used_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_qual
    hz_src_qual #(.REG_W(REG_W)) u_qual (
      .reg_i  (src[s]),
      .used_i (used[s]),
      .live_o (live[s])
    );
  end

  // with forwarding only a load in execute is too late to bypass
  assign stg_dst[STG_EX]  = ex_dst_i;
  assign stg_wr[STG_EX]   = ex_wr_i & (LOAD_ONLY ? ex_rd_i : 1'b1);
  assign stg_dst[STG_MEM] = mem_dst_i;
  assign stg_wr[STG_MEM]  = mem_wr_i;
  assign stg_dst[STG_WB]  = wb_dst_i;
  assign stg_wr[STG_WB]   = wb_wr_i;

  for (genvar g = 0; g < NUM_STG; g++) begin : g_stg
    hz_stage_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_cmp (
      .src_i  (src),
      .live_i (live),
      .dst_i  (stg_dst[g]),
      .wr_i   (stg_wr[g]),
      .hit_o  (hit[g])
    );
  end

  hz_ctrl #(.MODE(MODE), .WRITE_FIRST(WRITE_FIRST)) u_ctrl (
    .hit_i     (hit),
    .pc_we_o   (pc_we_o),
    .ifid_we_o (ifid_we_o),
    .bubble_o  (bubble_o)
  );
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter hz_mode_e    MODE  = MODE_STALL_ONLY
) (
  input logic [REG_W-1:0] src1_i,
  input logic             src1_used_i,
  input logic [REG_W-1:0] src2_i,
  input logic             src2_used_i,
  input logic [REG_W-1:0] ex_dst_i,
  input logic             ex_wr_i,
  input logic             ex_rd_i,
  input logic             mem_wr_i,
  input logic             wb_wr_i,
  input logic             pc_we_o,
  input logic             ifid_we_o,
  input logic             bubble_o
);
  logic no_live_src;
  logic ex_match;

  assign no_live_src = !(src1_used_i && src1_i != '0) && !(src2_used_i && src2_i != '0);
  assign ex_match    = ex_wr_i && ((src1_used_i && src1_i != '0 && src1_i == ex_dst_i) ||
                                   (src2_used_i && src2_i != '0 && src2_i == ex_dst_i));

  always_comb begin
    assert_ctrl_code_R7: assert ((pc_we_o == ifid_we_o) && (bubble_o == !pc_we_o))
      else $error("control code inconsistent");
    assert_no_live_src_R6: assert (!no_live_src || pc_we_o)
      else $error("stall without a live source");
    assert_no_writer_R4: assert (ex_wr_i || mem_wr_i || wb_wr_i || pc_we_o)
      else $error("stall without any writer");
    assert_load_only_R8: assert (MODE != MODE_LOAD_USE || ex_rd_i || pc_we_o)
      else $error("load-use stall without a load");
    assert_ex_match_R1: assert (!ex_match || (MODE == MODE_LOAD_USE && !ex_rd_i) || !pc_we_o)
      else $error("execute match missed");
  end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W), .MODE(MODE)) u_chk (
  .src1_i      (src1_i),
  .src1_used_i (src1_used_i),
  .src2_i      (src2_i),
  .src2_used_i (src2_used_i),
  .ex_dst_i    (ex_dst_i),
  .ex_wr_i     (ex_wr_i),
  .ex_rd_i     (ex_rd_i),
  .mem_wr_i    (mem_wr_i),
  .wb_wr_i     (wb_wr_i),
  .pc_we_o     (pc_we_o),
  .ifid_we_o   (ifid_we_o),
  .bubble_o    (bubble_o)
);

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  import hz_pkg::*;

  localparam int unsigned REG_W    = 5;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WD_LIMIT = 5000;

  logic clk = 1'b0;
  always #(CLK_PER / 2) clk = ~clk;

  logic [REG_W-1:0] src1, src2, ex_dst, mem_dst, wb_dst;
  logic src1_used, src2_used, ex_wr, ex_rd, mem_wr, wb_wr;
  logic [2:0] o0, o1, o2;

  hazard_unit #(.REG_W(REG_W)) u0 (
    .src1_i(src1), .src1_used_i(src1_used), .src2_i(src2), .src2_used_i(src2_used),
    .ex_dst_i(ex_dst), .ex_wr_i(ex_wr), .ex_rd_i(ex_rd),
    .mem_dst_i(mem_dst), .mem_wr_i(mem_wr), .wb_dst_i(wb_dst), .wb_wr_i(wb_wr),
    .pc_we_o(o0[2]), .ifid_we_o(o0[1]), .bubble_o(o0[0]));

  hazard_unit #(.REG_W(REG_W), .MODE(MODE_LOAD_USE)) u1 (
    .src1_i(src1), .src1_used_i(src1_used), .src2_i(src2), .src2_used_i(src2_used),
    .ex_dst_i(ex_dst), .ex_wr_i(ex_wr), .ex_rd_i(ex_rd),
    .mem_dst_i(mem_dst), .mem_wr_i(mem_wr), .wb_dst_i(wb_dst), .wb_wr_i(wb_wr),
    .pc_we_o(o1[2]), .ifid_we_o(o1[1]), .bubble_o(o1[0]));

  hazard_unit #(.REG_W(REG_W), .WRITE_FIRST(1'b1)) u2 (
    .src1_i(src1), .src1_used_i(src1_used), .src2_i(src2), .src2_used_i(src2_used),
    .ex_dst_i(ex_dst), .ex_wr_i(ex_wr), .ex_rd_i(ex_rd),
    .mem_dst_i(mem_dst), .mem_wr_i(mem_wr), .wb_dst_i(wb_dst), .wb_wr_i(wb_wr),
    .pc_we_o(o2[2]), .ifid_we_o(o2[1]), .bubble_o(o2[0]));

  typedef struct {
    string      tag;
    logic [2:0] e0, e1, e2;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  function automatic bit dep(logic [REG_W-1:0] s, logic u, logic [REG_W-1:0] d, logic w);
    return u && (s != '0) && w && (s == d);
  endfunction

  task automatic apply(string tag,
                       logic [REG_W-1:0] s1, logic u1, logic [REG_W-1:0] s2, logic u2,
                       logic [REG_W-1:0] exd, logic exw, logic exr,
                       logic [REG_W-1:0] md, logic mw, logic [REG_W-1:0] wd, logic ww);
    item_t it;
    bit h_ex, h_ld, h_mem, h_wb;
    @(posedge clk);
    #1;
    src1 = s1; src1_used = u1; src2 = s2; src2_used = u2;
    ex_dst = exd; ex_wr = exw; ex_rd = exr;
    mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
    h_ex  = dep(s1, u1, exd, exw) || dep(s2, u2, exd, exw);
    h_ld  = dep(s1, u1, exd, exw && exr) || dep(s2, u2, exd, exw && exr);
    h_mem = dep(s1, u1, md, mw) || dep(s2, u2, md, mw);
    h_wb  = dep(s1, u1, wd, ww) || dep(s2, u2, wd, ww);
    it.tag = tag;
    it.e0 = (h_ex || h_mem || h_wb) ? 3'b001 : 3'b110;
    it.e1 = h_ld ? 3'b001 : 3'b110;
    it.e2 = (h_ex || h_mem) ? 3'b001 : 3'b110;
    sb.push_back(it);
  endtask

  task automatic cmp(string tag, string inst, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, inst, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      cmp(it.tag, "u0", o0, it.e0);
      cmp(it.tag, "u1", o1, it.e1);
      cmp(it.tag, "u2", o2, it.e2);
    end
  end

  initial begin
    src1 = '0; src2 = '0; ex_dst = '0; mem_dst = '0; wb_dst = '0;
    src1_used = 0; src2_used = 0; ex_wr = 0; ex_rd = 0; mem_wr = 0; wb_wr = 0;
    apply("R7 idle",           5'd0,  0, 5'd0,  0, 5'd0,  0, 0, 5'd0,  0, 5'd0,  0);
    apply("R7 no match",       5'd3,  1, 5'd4,  1, 5'd7,  1, 0, 5'd8,  1, 5'd9,  1);
    apply("R1 alu in ex src1", 5'd3,  1, 5'd4,  1, 5'd3,  1, 0, 5'd0,  0, 5'd0,  0);
    apply("R8 load in ex src2",5'd3,  1, 5'd12, 1, 5'd12, 1, 1, 5'd0,  0, 5'd0,  0);
    apply("R2 mem src2",       5'd1,  1, 5'd6,  1, 5'd9,  1, 0, 5'd6,  1, 5'd0,  0);
    apply("R2 mem src1",       5'd17, 1, 5'd2,  1, 5'd0,  0, 0, 5'd17, 1, 5'd0,  0);
    apply("R3 wb src1",        5'd21, 1, 5'd2,  1, 5'd9,  1, 0, 5'd8,  1, 5'd21, 1);
    apply("R3 wb src2",        5'd5,  1, 5'd30, 1, 5'd0,  0, 0, 5'd0,  0, 5'd30, 1);
    apply("R4 store in ex",    5'd3,  1, 5'd4,  1, 5'd3,  0, 1, 5'd4,  0, 5'd3,  0);
    apply("R5 unused src2 ex", 5'd3,  1, 5'd11, 0, 5'd11, 1, 1, 5'd11, 1, 5'd11, 1);
    apply("R5 unused src1",    5'd14, 0, 5'd2,  1, 5'd14, 1, 1, 5'd0,  0, 5'd0,  0);
    apply("R6 reg zero",       5'd0,  1, 5'd0,  1, 5'd0,  1, 1, 5'd0,  1, 5'd0,  1);
    apply("R9 msb differs",    5'd19, 1, 5'd4,  1, 5'd3,  1, 1, 5'd0,  0, 5'd0,  0);
    apply("R9 msb match",      5'd19, 1, 5'd4,  1, 5'd19, 1, 1, 5'd0,  0, 5'd0,  0);
    apply("R8 load mem only",  5'd8,  1, 5'd2,  1, 5'd9,  1, 1, 5'd8,  1, 5'd0,  0);
    apply("R1 all stages",     5'd31, 1, 5'd31, 1, 5'd31, 1, 0, 5'd31, 1, 5'd31, 1);
    apply("R7 back to run",    5'd2,  1, 5'd3,  1, 5'd4,  1, 1, 5'd5,  1, 5'd6,  1);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule